// File: doc/BRIEF.md
# DMA channel address and trigger controller

This block is the per-channel control core of a DMA engine. It keeps each address in two copies. Software writes a shadow copy and only hardware writes the active copy. Software programs the shadow begin address, the shadow current address, a wrap size (the number of bursts before a wrap) and a wrap step (the distance the begin address moves on a wrap). When a transfer starts, the active registers load from their shadows. After that, hardware alone moves them: it steps by a signed amount per word, wraps after the programmed number of bursts, and rewinds to the begin address on a sync error.

The same block latches peripheral triggers into a pending request, which the channel's burst-start handshake consumes. A trigger that arrives while a request is still pending is lost, and an overrun flag records the loss. A single interrupt line reports three events: the beginning or end of a transfer (a mode input selects which), and a new overrun. A halt command, or an emulation halt while free-run is off, freezes all burst-level activity at its current point.

Top module: `dma_chan_ctrl`

## Requirements
- R1: A software write (`sw_we`=1) loads `sw_wdata` into the shadow register chosen by `sw_sel`: 0 = begin address, 1 = current address, 2 = wrap size (low CW bits), 3 = wrap step. No hardware event ever changes a shadow register.
- R2: `xfer_start` loads the active begin address from the shadow begin address, the active current address from the shadow current address, and the wrap counter from the wrap size, all in the next cycle. It takes priority over every other address event.
- R3: Each `word_done` adds the signed two's-complement `word_step` to `cur_addr`, modulo 2^AW.
- R4: On `burst_done`, a non-zero wrap counter decrements by one. A zero wrap counter causes a wrap: the active begin address advances by the wrap step, `cur_addr` takes the new begin address, and the counter reloads from the wrap size. A wrap overrides a `word_done` in the same cycle.
- R5: `sync_err` (without `xfer_start`) loads `cur_addr` from the active begin address, leaves the begin address and the wrap counter unchanged, and overrides burst and word events in that cycle.
- R6: `per_trig` sets `pending`. An effective `burst_start` clears it. If both occur in the same cycle, `pending` stays set.
- R7: A `per_trig` that arrives while `pending` is set, with no effective `burst_start` in the same cycle, is dropped and sets `ovr_flag`.
- R8: `err_clr` clears `ovr_flag` unless a new overrun occurs in the same cycle; in that case the flag stays set.
- R9: `chan_int` is a one-cycle pulse in the cycle after either of two events. The first is `chan_ie`=1 together with `xfer_start` (when `int_at_end`=0) or with `xfer_done` (when `int_at_end`=1). The second is `ovr_ie`=1 together with an overrun that sets a previously clear `ovr_flag`.
- R10: A halt request is `halt_cmd`=1, or `emu_halt`=1 while `free_run`=0. While it is present, `word_done`, `burst_done` and `burst_start` have no effect. `halted` reflects the request one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_we | input | 1 | Software shadow write strobe |
| sw_sel | input | 2 | Shadow register select |
| sw_wdata | input | AW | Software write data |
| word_step | input | AW | Signed per-word address step |
| xfer_start | input | 1 | Transfer begins |
| xfer_done | input | 1 | Transfer ends |
| burst_start | input | 1 | Burst-start handshake, consumes the pending request |
| burst_done | input | 1 | Burst ends |
| word_done | input | 1 | One word moved |
| sync_err | input | 1 | Sync error, rewind to begin address |
| per_trig | input | 1 | Peripheral trigger |
| err_clr | input | 1 | Clear overrun flag |
| chan_ie | input | 1 | Transfer interrupt enable |
| int_at_end | input | 1 | Transfer interrupt at end (1) or beginning (0) |
| ovr_ie | input | 1 | Overrun interrupt enable |
| halt_cmd | input | 1 | Halt command |
| emu_halt | input | 1 | Emulation halt request |
| free_run | input | 1 | Ignore emulation halt |
| cur_addr | output | AW | Active current address |
| beg_addr | output | AW | Active begin address |
| pending | output | 1 | Trigger pending |
| ovr_flag | output | 1 | Overrun flag |
| chan_int | output | 1 | Channel interrupt pulse |
| halted | output | 1 | Channel held at a halt point |

## Verification
Every output of this block is registered, so the result of any stimulus appears exactly one clock after the rising edge that samples it. This holds for an address reload, a wrap, an overrun, an interrupt pulse and the halted indication. The bench changes inputs on the falling edge and advances its reference model at the rising edge. It compares all outputs at the following falling edge, which is the first point where the due value is stable. Simultaneous cases such as a trigger together with a burst start, a clear together with an overrun, or a wrap together with a word step are driven in a single cycle, so their priority shows in the next comparison.

// File: rtl/dma_chan_pkg.sv
// Package: shared types for the DMA channel controller.
// Assumes: the shadow select encoding below is the software-visible one.
package dma_chan_pkg;
    typedef enum logic [1:0] {
        SEL_BEG   = 2'd0,
        SEL_CUR   = 2'd1,
        SEL_WSIZE = 2'd2,
        SEL_WSTEP = 2'd3
    } shadow_sel_e;
endpackage

// File: rtl/dma_shadow_regs.sv
// Module: software-owned shadow registers.
// What it does: holds begin address, current address, wrap size, wrap step.
// Assumes: only the software write port updates these; CW <= AW.
module dma_shadow_regs
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] beg_sh,
    output logic [AW-1:0] cur_sh,
    output logic [CW-1:0] wsize_sh,
    output logic [AW-1:0] wstep_sh
);
    shadow_sel_e sel_e;
    assign sel_e = shadow_sel_e'(sel);

    // Purpose: capture a software write into the selected shadow register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beg_sh   <= '0;
            cur_sh   <= '0;
            wsize_sh <= '0;
            wstep_sh <= '0;
        end else if (we) begin
            case (sel_e)
                SEL_BEG:   beg_sh   <= wdata;
                SEL_CUR:   cur_sh   <= wdata;
                SEL_WSIZE: wsize_sh <= wdata[CW-1:0];
                default:   wstep_sh <= wdata;
            endcase
        end
    end
endmodule

// File: rtl/dma_addr_engine.sv
// Module: hardware-owned active address registers and wrap counter.
// What it does: reloads at transfer start, steps per word, wraps per burst
// count, rewinds on sync error.
// Assumes: word/burst strobes arrive already gated by the halt logic.
module dma_addr_engine #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          sync_err,
    input  logic          word_ok,
    input  logic          burst_end_ok,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] beg_sh,
    input  logic [AW-1:0] cur_sh,
    input  logic [CW-1:0] wsize_sh,
    input  logic [AW-1:0] wstep_sh,
    output logic [AW-1:0] beg_act,
    output logic [AW-1:0] cur_act
);
    logic [CW-1:0] wrap_cnt;
    logic          wrap_now;
    logic [AW-1:0] beg_wrapped;

    // Purpose: decide whether this burst end is a wrap and its new base.
    always_comb begin
        wrap_now    = burst_end_ok && (wrap_cnt == '0);
        beg_wrapped = beg_act + wstep_sh;
    end

    // Purpose: update active begin, current address and wrap count by priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beg_act  <= '0;
            cur_act  <= '0;
            wrap_cnt <= '0;
        end else if (start) begin
            beg_act  <= beg_sh;
            cur_act  <= cur_sh;
            wrap_cnt <= wsize_sh;
        end else if (sync_err) begin
            cur_act  <= beg_act;
        end else if (wrap_now) begin
            beg_act  <= beg_wrapped;
            cur_act  <= beg_wrapped;
            wrap_cnt <= wsize_sh;
        end else begin
            if (burst_end_ok) begin
                wrap_cnt <= wrap_cnt - 1'b1;
            end
            if (word_ok) begin
                cur_act <= cur_act + step;
            end
        end
    end
endmodule

// File: rtl/dma_trig_latch.sv
// Module: peripheral trigger latch with overrun detection.
// What it does: holds one pending request; a second trigger while pending is
// lost and sets the overrun flag.
// Assumes: burst_ok is the halt-gated burst-start handshake.
module dma_trig_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic burst_ok,
    input  logic err_clr,
    output logic pending,
    output logic ovr_flag,
    output logic ovr_rise
);
    logic ovr_set;

    // Purpose: detect a lost trigger and a fresh overrun.
    always_comb begin
        ovr_set  = trig && pending && !burst_ok;
        ovr_rise = ovr_set && !ovr_flag;
    end

    // Purpose: maintain the pending request and the sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            pending  <= trig || (pending && !burst_ok);
            ovr_flag <= ovr_set || (ovr_flag && !err_clr);
        end
    end
endmodule

// File: rtl/dma_irq_gen.sv
// Module: channel interrupt pulse generator.
// What it does: pulses for transfer begin/end (mode select) and new overrun.
// Assumes: all event inputs are single-cycle strobes.
module dma_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_ie,
    input  logic at_end,
    input  logic start,
    input  logic done,
    input  logic ovr_ie,
    input  logic ovr_rise,
    output logic irq
);
    logic xfer_evt;

    // Purpose: pick the transfer edge that the mode selects.
    always_comb begin
        xfer_evt = at_end ? done : start;
    end

    // Purpose: register the combined interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= (chan_ie && xfer_evt) || (ovr_ie && ovr_rise);
        end
    end
endmodule

// File: rtl/dma_chan_ctrl.sv
// Module: top of the DMA channel address and trigger controller.
// What it does: joins shadow registers, active address engine, trigger
// latch and interrupt generator; gates burst activity on a halt request.
// Assumes: all strobes are synchronous to clk and one cycle wide.
module dma_chan_ctrl #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we,
    input  logic [1:0]    sw_sel,
    input  logic [AW-1:0] sw_wdata,
    input  logic [AW-1:0] word_step,
    input  logic          xfer_start,
    input  logic          xfer_done,
    input  logic          burst_start,
    input  logic          burst_done,
    input  logic          word_done,
    input  logic          sync_err,
    input  logic          per_trig,
    input  logic          err_clr,
    input  logic          chan_ie,
    input  logic          int_at_end,
    input  logic          ovr_ie,
    input  logic          halt_cmd,
    input  logic          emu_halt,
    input  logic          free_run,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] beg_addr,
    output logic          pending,
    output logic          ovr_flag,
    output logic          chan_int,
    output logic          halted
);
    logic [AW-1:0] beg_sh;
    logic [AW-1:0] cur_sh;
    logic [CW-1:0] wsize_sh;
    logic [AW-1:0] wstep_sh;
    logic          halt_req;
    logic          word_ok;
    logic          burst_end_ok;
    logic          burst_ok;
    logic          ovr_rise;

    // Purpose: form the halt request and gate the burst-level strobes.
    always_comb begin
        halt_req     = halt_cmd || (emu_halt && !free_run);
        word_ok      = word_done && !halt_req;
        burst_end_ok = burst_done && !halt_req;
        burst_ok     = burst_start && !halt_req;
    end

    // Purpose: report that the channel sits at a halt point.
    always_ff @(posedge clk) begin
        if (!rst_n) halted <= 1'b0;
        else        halted <= halt_req;
    end

    dma_shadow_regs #(.AW(AW), .CW(CW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .we(sw_we), .sel(sw_sel), .wdata(sw_wdata),
        .beg_sh(beg_sh), .cur_sh(cur_sh), .wsize_sh(wsize_sh), .wstep_sh(wstep_sh)
    );

    dma_addr_engine #(.AW(AW), .CW(CW)) u_addr (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .sync_err(sync_err),
        .word_ok(word_ok), .burst_end_ok(burst_end_ok), .step(word_step),
        .beg_sh(beg_sh), .cur_sh(cur_sh), .wsize_sh(wsize_sh), .wstep_sh(wstep_sh),
        .beg_act(beg_addr), .cur_act(cur_addr)
    );

    dma_trig_latch u_trig (
        .clk(clk), .rst_n(rst_n), .trig(per_trig), .burst_ok(burst_ok),
        .err_clr(err_clr), .pending(pending), .ovr_flag(ovr_flag), .ovr_rise(ovr_rise)
    );

    dma_irq_gen u_irq (
        .clk(clk), .rst_n(rst_n), .chan_ie(chan_ie), .at_end(int_at_end),
        .start(xfer_start), .done(xfer_done), .ovr_ie(ovr_ie),
        .ovr_rise(ovr_rise), .irq(chan_int)
    );
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
// Module: property checker bound to dma_chan_ctrl.
// What it does: checks reload, rewind, trigger and halt rules over time.
// Assumes: bound with the port map below; synchronous active-low reset.
module dma_chan_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sw_we,
    input logic          xfer_start,
    input logic          sync_err,
    input logic          burst_start,
    input logic          per_trig,
    input logic          err_clr,
    input logic          halt_cmd,
    input logic          emu_halt,
    input logic          free_run,
    input logic [AW-1:0] beg_sh,
    input logic [AW-1:0] cur_sh,
    input logic [AW-1:0] cur_addr,
    input logic [AW-1:0] beg_addr,
    input logic          pending,
    input logic          ovr_flag,
    input logic          halted
);
    logic stop_req;
    assign stop_req = halt_cmd || (emu_halt && !free_run);

    // R1
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> ($stable(beg_sh) && $stable(cur_sh)));
    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (cur_addr == $past(cur_sh) && beg_addr == $past(beg_sh)));
    // R5
    sync_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && !xfer_start) |=> (cur_addr == $past(beg_addr) && $stable(beg_addr)));
    // R6
    trig_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_trig |=> pending);
    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_trig && pending && !(burst_start && !stop_req)) |=> ovr_flag);
    // R8
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !per_trig) |=> !ovr_flag);
    // R10
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !xfer_start && !sync_err) |=> ($stable(cur_addr) && $stable(beg_addr)));
    // R10
    halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> halted);
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .xfer_start(xfer_start),
    .sync_err(sync_err), .burst_start(burst_start), .per_trig(per_trig),
    .err_clr(err_clr), .halt_cmd(halt_cmd), .emu_halt(emu_halt),
    .free_run(free_run), .beg_sh(beg_sh), .cur_sh(cur_sh),
    .cur_addr(cur_addr), .beg_addr(beg_addr), .pending(pending),
    .ovr_flag(ovr_flag), .halted(halted)
);

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int MASK = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_we = 0; logic [1:0] sw_sel = 0; logic [AW-1:0] sw_wdata = 0;
    logic [AW-1:0] word_step = 0;
    logic xfer_start = 0, xfer_done = 0, burst_start = 0, burst_done = 0;
    logic word_done = 0, sync_err = 0, per_trig = 0, err_clr = 0;
    logic chan_ie = 0, int_at_end = 0, ovr_ie = 0;
    logic halt_cmd = 0, emu_halt = 0, free_run = 0;
    logic [AW-1:0] cur_addr, beg_addr;
    logic pending, ovr_flag, chan_int, halted;

    always #10 clk = ~clk; // 50 MHz

    dma_chan_ctrl #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .word_step(word_step), .xfer_start(xfer_start), .xfer_done(xfer_done),
        .burst_start(burst_start), .burst_done(burst_done), .word_done(word_done),
        .sync_err(sync_err), .per_trig(per_trig), .err_clr(err_clr),
        .chan_ie(chan_ie), .int_at_end(int_at_end), .ovr_ie(ovr_ie),
        .halt_cmd(halt_cmd), .emu_halt(emu_halt), .free_run(free_run),
        .cur_addr(cur_addr), .beg_addr(beg_addr), .pending(pending),
        .ovr_flag(ovr_flag), .chan_int(chan_int), .halted(halted)
    );

    // Reference model state (plain integers)
    int m_sbeg = 0, m_scur = 0, m_ssize = 0, m_sstep = 0;
    int m_beg = 0, m_cur = 0, m_cnt = 0;
    int m_pend = 0, m_ovr = 0, m_int = 0, m_halt = 0;
    int checks = 0, fails = 0;
    bit done_flag = 0;
    string req = "R2";

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check({req, " cur_addr"}, int'(cur_addr), m_cur);
        check({req, " beg_addr"}, int'(beg_addr), m_beg);
        check({req, " pending"},  int'(pending),  m_pend);
        check({req, " ovr_flag"}, int'(ovr_flag), m_ovr);
        check({req, " chan_int"}, int'(chan_int), m_int);
        check({req, " halted"},   int'(halted),   m_halt);
    endtask

    // Advance the model from the inputs present now, take one clock, compare.
    task automatic tick();
        int stop, w, b, bs, trig_lost, nb;
        stop = (halt_cmd || (emu_halt && !free_run)) ? 1 : 0;
        w  = (word_done && !stop) ? 1 : 0;
        b  = (burst_done && !stop) ? 1 : 0;
        bs = (burst_start && !stop) ? 1 : 0;
        if (xfer_start) begin
            m_beg = m_sbeg; m_cur = m_scur; m_cnt = m_ssize;
        end else if (sync_err) begin
            m_cur = m_beg;
        end else if (b && m_cnt == 0) begin
            nb = (m_beg + m_sstep) & MASK;
            m_beg = nb; m_cur = nb; m_cnt = m_ssize;
        end else begin
            if (b) m_cnt = m_cnt - 1;
            if (w) m_cur = (m_cur + int'(word_step)) & MASK;
        end
        trig_lost = (per_trig && m_pend && !bs) ? 1 : 0;
        m_int = ((chan_ie && (int_at_end ? xfer_done : xfer_start)) ||
                 (ovr_ie && trig_lost && !m_ovr)) ? 1 : 0;
        m_pend = (per_trig || (m_pend && !bs)) ? 1 : 0;
        m_ovr = (trig_lost || (m_ovr && !err_clr)) ? 1 : 0;
        m_halt = stop;
        if (sw_we) begin
            case (sw_sel)
                2'd0: m_sbeg = int'(sw_wdata);
                2'd1: m_scur = int'(sw_wdata);
                2'd2: m_ssize = int'(sw_wdata[CW-1:0]);
                default: m_sstep = int'(sw_wdata);
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
        sw_we = 0; xfer_start = 0; xfer_done = 0; burst_start = 0; burst_done = 0;
        word_done = 0; sync_err = 0; per_trig = 0; err_clr = 0;
    endtask

    task automatic wr(input int sel, input int data);
        sw_we = 1; sw_sel = 2'(sel); sw_wdata = AW'(data);
        tick();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        req = "R1"; // reset state: everything zero
        compare_all();

        // R1: program shadows through each select code
        wr(0, 'h1000); wr(1, 'h1004); wr(2, 2); wr(3, 'h0100);
        word_step = 16'd2;
        check("R1 no active change", int'(cur_addr), 0);

        // R2: transfer start loads actives; write in same cycle uses old shadow
        req = "R2";
        xfer_start = 1; sw_we = 1; sw_sel = 2'd1; sw_wdata = 16'h2222; tick();
        check("R2 cur from shadow", int'(cur_addr), 'h1004);
        wr(1, 'h1004);

        // R3: positive and negative word steps
        req = "R3";
        for (int i = 0; i < 3; i++) begin word_done = 1; tick(); end
        check("R3 step +2", int'(cur_addr), 'h100A);
        word_step = 16'hFFFD;
        word_done = 1; tick();
        check("R3 step -3", int'(cur_addr), 'h1007);
        word_step = 16'd2;

        // R4: two bursts count down, third wraps; wrap beats word step
        req = "R4";
        burst_done = 1; word_done = 1; tick();
        burst_done = 1; tick();
        burst_done = 1; word_done = 1; tick();
        check("R4 wrap begin", int'(beg_addr), 'h1100);
        check("R4 wrap cur", int'(cur_addr), 'h1100);
        word_done = 1; tick();

        // R5: sync error rewinds to begin, beats burst end
        req = "R5";
        sync_err = 1; burst_done = 1; word_done = 1; tick();
        check("R5 rewind", int'(cur_addr), 'h1100);
        check("R5 begin held", int'(beg_addr), 'h1100);

        // R2 again: restart shows shadows untouched by hardware
        req = "R2";
        xfer_start = 1; tick();
        check("R2 shadow intact", int'(beg_addr), 'h1000);

        // R6: trigger, consume, simultaneous
        req = "R6";
        per_trig = 1; tick();
        burst_start = 1; tick();
        per_trig = 1; tick();
        per_trig = 1; burst_start = 1; tick();
        check("R6 simultaneous keeps pending", int'(pending), 1);
        check("R6 no overrun", int'(ovr_flag), 0);

        // R7 + R9: overrun with interrupt enable
        req = "R7";
        ovr_ie = 1;
        per_trig = 1; tick();
        check("R7 overrun", int'(ovr_flag), 1);
        check("R9 ovr irq", int'(chan_int), 1);
        per_trig = 1; tick();
        check("R9 no irq on repeat", int'(chan_int), 0);

        // R8: clear, and clear against a new overrun
        req = "R8";
        err_clr = 1; tick();
        check("R8 cleared", int'(ovr_flag), 0);
        err_clr = 1; per_trig = 1; tick();
        check("R8 overrun wins", int'(ovr_flag), 1);
        err_clr = 1; burst_start = 1; tick();
        ovr_ie = 0;

        // R9: transfer interrupt at beginning then at end
        req = "R9";
        chan_ie = 1; int_at_end = 0;
        xfer_start = 1; tick();
        check("R9 begin irq", int'(chan_int), 1);
        xfer_done = 1; tick();
        check("R9 no irq at end in begin mode", int'(chan_int), 0);
        int_at_end = 1;
        xfer_start = 1; tick();
        xfer_done = 1; tick();
        check("R9 end irq", int'(chan_int), 1);
        chan_ie = 0;

        // R10: halt command and emulation halt freeze burst activity
        req = "R10";
        per_trig = 1; tick();
        halt_cmd = 1; word_done = 1; burst_done = 1; burst_start = 1; tick();
        check("R10 halted", int'(halted), 1);
        check("R10 pending kept", int'(pending), 1);
        halt_cmd = 0; emu_halt = 1; word_done = 1; tick();
        check("R10 emu halt freeze", int'(cur_addr), 'h1004);
        free_run = 1; word_done = 1; tick();
        check("R10 free run steps", int'(cur_addr), 'h1006);
        emu_halt = 0; free_run = 0; tick();
        check("R10 released", int'(halted), 0);

        finish_run();
    end
endmodule